// File: doc/BRIEF.md
# Synchronous FIFO with Sequentially Loaded Threshold Registers

This block is a single-clock first-in first-out buffer, nine bits wide and a parameterised number of words deep, with almost-empty and almost-full indications whose thresholds come from four small offset registers. Software or a neighbouring controller sets the thresholds through the ordinary data input. It holds the configuration select low and pulses the write enable. Each write lands in the register named by a two-bit rotating pointer, and the pointer then steps to the next register.

The same pointer serves readback. With the configuration select low and both read enables low, each clock edge copies the selected register, zero-extended, onto the data output and advances the pointer. The pointer is never cleared by leaving configuration mode, so a later session continues where the earlier one stopped. With the configuration select high, the buffer accepts writes and reads normally. Writes into a full buffer and reads from an empty one are dropped.

Top module: `prog_flag_fifo`

## Requirements
- R1: With cfg_sel_n low and wr_req_n low, a rising clock edge stores din into the offset register selected by the pointer, and the word count of the buffer does not change.
- R2: The pointer visits the registers in this order: empty-threshold low byte (index 0), empty-threshold high part (index 1), full-threshold low byte (index 2), full-threshold high part (index 3).
- R3: After index 3, the next configuration access wraps to index 0, so a fifth consecutive load write overwrites the empty-threshold low byte.
- R4: Raising cfg_sel_n restores normal buffer writes and reads. The pointer keeps its position, so the first access of the next session goes to the register after the last one touched.
- R5: With cfg_sel_n low and both read enables low, dout takes the selected register's value, zero-extended to 9 bits, at the clock edge, and the pointer advances by one.
- R6: After reset the buffer is empty, dout is 0, the pointer is at index 0, both low-byte registers hold 0x007 and both high-part registers hold 0.
- R7: A low-byte register keeps din[7:0]. A high-part register keeps din[HI_W-1:0] with HI_W = log2(DEPTH)-8 (3 bits for 2048 words). All other bits read back as zero.
- R8: If a load write and an offset read are requested in the same cycle, only the write takes effect: dout holds its value and the pointer advances exactly once.
- R9: almost_empty is high whenever the stored word count is at most the empty threshold {high part, low byte}.
- R10: almost_full is high whenever DEPTH minus the word count is at most the full threshold {high part, low byte}.
- R11: full is high at DEPTH words and empty at zero words. A write while full and a read while empty are ignored and leave the stored data and order intact.
- R12: In normal mode a read with both read enables low presents the oldest word on dout at that clock edge, and words leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every register in the block |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_req_n | input | 1 | Write enable, active low (load write when cfg_sel_n is low) |
| cfg_sel_n | input | 1 | Configuration select, active low |
| rd_req_a_n | input | 1 | First read enable, active low |
| rd_req_b_n | input | 1 | Second read enable, active low; a read needs both low |
| din | input | 9 | Write data or offset load value |
| dout | output | 9 | Registered read data or offset readback |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no words |
| almost_empty | output | 1 | Word count at or below the empty threshold |
| almost_full | output | 1 | Free space at or below the full threshold |

## Verification
A load write and an offset readback can both be requested in one cycle, because both use the configuration select and the shared pointer. The bench causes this by driving wr_req_n, rd_req_a_n and rd_req_b_n low together with cfg_sel_n low. It then requires that dout keeps the value from the previous readback. It also requires that the next lone readback returns the register one position past the collision, which shows the pointer moved once and the written register took the data.

// File: rtl/pff_pkg.sv
// Shared definitions for the programmable-threshold FIFO.
// Assumes the offset pointer order is fixed: empty low, empty high,
// full low, full high. Bit 1 of the index picks the threshold and
// bit 0 picks the low byte or the high part.
package pff_pkg;

    // Width of every low-byte offset register.
    localparam int LO_W = 8;

    // Default value loaded into each low-byte register at reset.
    localparam int LO_RST = 7;

    // Index of the offset register under the rotating pointer.
    typedef enum logic [1:0] {
        OFS_E_LO = 2'd0,
        OFS_E_HI = 2'd1,
        OFS_F_LO = 2'd2,
        OFS_F_HI = 2'd3
    } ofs_sel_t;

endpackage

// File: rtl/pff_offset_bank.sv
// Four threshold registers behind one rotating pointer.
// What it does: a load write stores din into the selected register. A
// readback request offers the selected register on rd_data and tells the
// parent to capture it. Either access steps the pointer by one.
// Assumes: load_we and rd_req are already qualified by configuration
// mode. A load write outranks a readback requested in the same cycle.
module pff_offset_bank
    import pff_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int AW     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_we,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] din,
    output logic              rd_take,
    output logic [DATA_W-1:0] rd_data,
    output logic [AW-1:0]     empty_ofs,
    output logic [AW-1:0]     full_ofs
);

    localparam int HI_W = AW - LO_W;

    ofs_sel_t sel_q;
    logic     step;

    logic [1:0][AW-1:0]     ofs_w;
    logic [1:0][DATA_W-1:0] lo_rb;
    logic [1:0][DATA_W-1:0] hi_rb;

    assign step    = load_we || rd_req;
    assign rd_take = rd_req && !load_we;

    // Pointer update: clear on reset, step once per configuration access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= OFS_E_LO;
        end else if (step) begin
            sel_q <= ofs_sel_t'(sel_q + 2'd1);
        end
    end

    // One low/high register pair for each threshold (0 = empty, 1 = full).
    for (genvar k = 0; k < 2; k++) begin : g_pair
        logic [LO_W-1:0] lo_q;
        logic [HI_W-1:0] hi_q;

        // Capture load data into the low or high half of this pair.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= LO_W'(LO_RST);
                hi_q <= '0;
            end else if (load_we && (sel_q[1] == k[0])) begin
                if (sel_q[0]) begin
                    hi_q <= din[HI_W-1:0];
                end else begin
                    lo_q <= din[LO_W-1:0];
                end
            end
        end

        assign ofs_w[k] = {hi_q, lo_q};
        assign lo_rb[k] = {{(DATA_W-LO_W){1'b0}}, lo_q};
        assign hi_rb[k] = {{(DATA_W-HI_W){1'b0}}, hi_q};
    end

    assign empty_ofs = ofs_w[0];
    assign full_ofs  = ofs_w[1];

    // Readback selection: bit 1 picks the pair, bit 0 picks the half.
    always_comb begin
        if (sel_q[0]) begin
            rd_data = hi_rb[sel_q[1]];
        end else begin
            rd_data = lo_rb[sel_q[1]];
        end
    end

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_we && sel_q == OFS_F_HI) |=> (sel_q == OFS_E_LO)); // R3

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_we && !rd_req) |=> $stable(sel_q)); // R4

    AST_READ_KEEPS_OFS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> ($stable(empty_ofs) && $stable(full_ofs))); // R5

endmodule

// File: rtl/pff_storage.sv
// Word store, read and write pointers, and occupancy count.
// What it does: accepts a push unless full and a pop unless empty, and
// presents the oldest word on head_data without a clock delay.
// Assumes: push and pop arrive already qualified by normal mode. DEPTH
// is a power of two so the pointers wrap on their own.
module pff_storage #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2048
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  logic                    pop,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       head_data,
    output logic [$clog2(DEPTH):0]  count,
    output logic                    full,
    output logic                    empty,
    output logic                    pop_ok
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_q;
    logic [AW-1:0]     rptr_q;
    logic [AW:0]       count_q;
    logic              push_ok;

    assign full      = (count_q == DEPTH_V);
    assign empty     = (count_q == '0);
    assign push_ok   = push && !full;
    assign pop_ok    = pop && !empty;
    assign count     = count_q;
    assign head_data = mem[rptr_q];

    // Array write: store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr_q] <= wdata;
        end
    end

    // Pointer and count update on accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) begin
                wptr_q <= wptr_q + 1'b1;
            end
            if (pop_ok) begin
                rptr_q <= rptr_q + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(count_q))); // R11

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (empty && $stable(rptr_q))); // R11

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R11

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q <= DEPTH_V)); // R11

endmodule

// File: rtl/pff_flags.sv
// Almost-empty and almost-full comparison.
// What it does: compares occupancy against the empty threshold and free
// space against the full threshold, both inclusive.
// Assumes: thresholds are AW bits wide and count is AW+1 bits wide.
module pff_flags #(
    parameter int DEPTH = 2048
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [$clog2(DEPTH):0] count,
    input  logic                   full,
    input  logic                   empty,
    input  logic [$clog2(DEPTH)-1:0] empty_ofs,
    input  logic [$clog2(DEPTH)-1:0] full_ofs,
    output logic                   almost_empty,
    output logic                   almost_full
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    logic [AW:0] free_words;

    // Threshold compare: both flags are inclusive at the threshold.
    always_comb begin
        free_words   = DEPTH_V - count;
        almost_empty = (count <= {1'b0, empty_ofs});
        almost_full  = (free_words <= {1'b0, full_ofs});
    end

    AST_EMPTY_IMPLIES_AE: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> almost_empty); // R9

    AST_FULL_IMPLIES_AF: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> almost_full); // R10

endmodule

// File: rtl/prog_flag_fifo.sv
// Top level of the programmable-threshold FIFO.
// What it does: decodes the active-low controls into load write, offset
// readback, push and pop, and registers dout from the buffer head or the
// offset bank.
// Assumes: one clock for everything, synchronous active-low reset,
// DEPTH a power of two with log2(DEPTH) between 9 and DATA_W+8.
module prog_flag_fifo #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req_n,
    input  logic              cfg_sel_n,
    input  logic              rd_req_a_n,
    input  logic              rd_req_b_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              empty,
    output logic              almost_empty,
    output logic              almost_full
);

    localparam int AW = $clog2(DEPTH);

    logic              cfg_mode;
    logic              wr_any;
    logic              rd_any;
    logic              load_we;
    logic              ofs_rd;
    logic              push;
    logic              pop;
    logic              pop_ok;
    logic              ofs_take;
    logic [DATA_W-1:0] head_data;
    logic [DATA_W-1:0] ofs_data;
    logic [AW:0]       fifo_count;
    logic [AW-1:0]     empty_ofs;
    logic [AW-1:0]     full_ofs;
    logic [DATA_W-1:0] dout_q;

    // Control decode: split each request by configuration mode.
    always_comb begin
        cfg_mode = !cfg_sel_n;
        wr_any   = !wr_req_n;
        rd_any   = !rd_req_a_n && !rd_req_b_n;
        load_we  = cfg_mode && wr_any;
        ofs_rd   = cfg_mode && rd_any;
        push     = !cfg_mode && wr_any;
        pop      = !cfg_mode && rd_any;
    end

    pff_offset_bank #(
        .DATA_W (DATA_W),
        .AW     (AW)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_we   (load_we),
        .rd_req    (ofs_rd),
        .din       (din),
        .rd_take   (ofs_take),
        .rd_data   (ofs_data),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    pff_storage #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .wdata     (din),
        .head_data (head_data),
        .count     (fifo_count),
        .full      (full),
        .empty     (empty),
        .pop_ok    (pop_ok)
    );

    pff_flags #(
        .DEPTH (DEPTH)
    ) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .count        (fifo_count),
        .full         (full),
        .empty        (empty),
        .empty_ofs    (empty_ofs),
        .full_ofs     (full_ofs),
        .almost_empty (almost_empty),
        .almost_full  (almost_full)
    );

    // Output register: capture the buffer head or the offset readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (pop_ok) begin
            dout_q <= head_data;
        end else if (ofs_take) begin
            dout_q <= ofs_data;
        end
    end

    assign dout = dout_q;

    AST_CFG_NO_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |=> $stable(fifo_count)); // R1

    AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_we && ofs_rd) |=> $stable(dout_q)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_any) |=> $stable(dout_q)); // R12

endmodule

// File: tb/prog_flag_fifo_test.sv
// Directed bench for prog_flag_fifo: one task per scenario.
module prog_flag_fifo_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 9;
    localparam int DEPTH      = 2048;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_req_n;
    logic          cfg_sel_n;
    logic          rd_req_a_n;
    logic          rd_req_b_n;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          full;
    logic          empty;
    logic          almost_empty;
    logic          almost_full;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    prog_flag_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_req_n     (wr_req_n),
        .cfg_sel_n    (cfg_sel_n),
        .rd_req_a_n   (rd_req_a_n),
        .rd_req_b_n   (rd_req_b_n),
        .din          (din),
        .dout         (dout),
        .full         (full),
        .empty        (empty),
        .almost_empty (almost_empty),
        .almost_full  (almost_full)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    // Drive one cycle (active-high arguments), return at the next negedge.
    task automatic cyc(input bit wr, input bit cfg, input bit ra, input bit rb,
                       input logic [DW-1:0] d);
        wr_req_n   = !wr;
        cfg_sel_n  = !cfg;
        rd_req_a_n = !ra;
        rd_req_b_n = !rb;
        din        = d;
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'((i * 37 + 11) & 9'h1FF);
    endfunction

    task automatic t_reset_state;
        check("R6 empty", int'(empty), 1);
        check("R6 full", int'(full), 0);
        check("R6 dout", int'(dout), 0);
        check("R9 almost_empty at reset", int'(almost_empty), 1);
        check("R10 almost_full at reset", int'(almost_full), 0);
        cyc(0, 1, 1, 1, '0); check("R6 R5 empty low default", int'(dout), 'h007);
        cyc(0, 1, 1, 1, '0); check("R6 R2 empty high default", int'(dout), 'h000);
        cyc(0, 1, 1, 1, '0); check("R6 R2 full low default", int'(dout), 'h007);
        cyc(0, 1, 1, 1, '0); check("R6 R2 full high default", int'(dout), 'h000);
        cyc(0, 1, 0, 1, '0); check("R5 single read enable ignored", int'(dout), 'h000);
    endtask

    task automatic t_load_wrap;
        cyc(1, 1, 0, 0, 9'h0AA);
        cyc(1, 1, 0, 0, 9'h1FF);
        cyc(1, 1, 0, 0, 9'h133);
        cyc(1, 1, 0, 0, 9'h002);
        cyc(1, 1, 0, 0, 9'h1A5);   // fifth write wraps to index 0
        check("R1 load writes leave buffer empty", int'(empty), 1);
        cyc(0, 0, 0, 0, '0);
        cyc(0, 1, 1, 1, '0); check("R7 high part keeps 3 bits", int'(dout), 'h007);
        cyc(0, 1, 1, 1, '0); check("R2 R7 full low keeps 8 bits", int'(dout), 'h033);
        cyc(0, 1, 1, 1, '0); check("R2 full high", int'(dout), 'h002);
        cyc(0, 1, 1, 1, '0); check("R3 fifth write hit empty low", int'(dout), 'h0A5);
    endtask

    task automatic t_partial;
        cyc(1, 1, 0, 0, 9'h000);   // index 1
        cyc(0, 0, 0, 0, '0);
        cyc(1, 0, 0, 0, 9'h155);   // normal write
        check("R4 normal write after leaving load", int'(empty), 0);
        cyc(1, 1, 0, 0, 9'h005);   // resumes at index 2
        cyc(0, 0, 0, 0, '0);
        cyc(1, 1, 0, 0, 9'h000);   // index 3
        cyc(1, 1, 0, 0, 9'h003);   // index 0
        cyc(0, 0, 0, 0, '0);
        cyc(0, 1, 1, 1, '0); check("R4 readback resumes at empty high", int'(dout), 'h000);
        cyc(0, 1, 1, 1, '0); check("R4 resumed write went to full low", int'(dout), 'h005);
        cyc(0, 1, 1, 1, '0); check("R4 full high", int'(dout), 'h000);
        cyc(0, 1, 1, 1, '0); check("R4 empty low", int'(dout), 'h003);
        check("R1 buffer holds one word", int'(empty), 0);
        check("R9 one word under threshold 3", int'(almost_empty), 1);
    endtask

    task automatic t_collide;
        cyc(1, 1, 1, 1, 9'h000);   // write index 1 and read together
        check("R8 dout held on collision", int'(dout), 'h003);
        cyc(0, 1, 1, 1, '0); check("R8 pointer stepped once", int'(dout), 'h005);
        cyc(0, 1, 1, 1, '0); check("R8 full high", int'(dout), 'h000);
        cyc(0, 1, 1, 1, '0); check("R8 empty low", int'(dout), 'h003);
        cyc(0, 1, 1, 1, '0); check("R8 written register holds 0", int'(dout), 'h000);
        cyc(0, 0, 0, 0, '0);
    endtask

    task automatic t_fifo_flags;
        int bad = 0;
        cyc(0, 0, 1, 1, '0);
        check("R12 head word on dout", int'(dout), 'h155);
        check("R11 empty after last read", int'(empty), 1);
        for (int k = 1; k <= DEPTH; k++) begin
            cyc(1, 0, 0, 0, pat(k));
            if (k == 3)    check("R9 count 3 at threshold 3", int'(almost_empty), 1);
            if (k == 4)    check("R9 count 4 above threshold", int'(almost_empty), 0);
            if (k == DEPTH-6) check("R10 free 6 above threshold 5", int'(almost_full), 0);
            if (k == DEPTH-5) check("R10 free 5 at threshold 5", int'(almost_full), 1);
            if (k == DEPTH-1) check("R11 not full one short", int'(full), 0);
        end
        check("R11 full at DEPTH", int'(full), 1);
        cyc(1, 0, 0, 0, 9'h1EE);   // ignored
        for (int k = 1; k <= DEPTH; k++) begin
            cyc(0, 0, 1, 1, '0);
            if (dout != pat(k)) begin
                if (bad == 0)
                    $display("FAIL R12 order word %0d: actual 0x%0h expected 0x%0h",
                             k, dout, pat(k));
                bad++;
            end
        end
        n_checks++;
        if (bad != 0) n_fails++;
        check("R11 write while full dropped", int'(empty), 1);
        cyc(0, 0, 1, 1, '0);
        check("R11 read while empty leaves dout", int'(dout), int'(pat(DEPTH)));
        cyc(1, 0, 0, 0, 9'h0C3);
        cyc(0, 0, 1, 1, '0);
        check("R11 pointers intact after ignored ops", int'(dout), 'h0C3);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        wr_req_n   = 1'b1;
        cfg_sel_n  = 1'b1;
        rd_req_a_n = 1'b1;
        rd_req_b_n = 1'b1;
        din        = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_load_wrap();
        t_partial();
        t_collide();
        t_fifo_flags();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule